// File: doc/BRIEF.md
# Memory Scrub Sequencer

The scrub sequencer walks main memory one ECC word at a time, from a programmed first address up to a programmed last address, and keeps stored data healthy between normal accesses. Each ECC word holds 32 data bits, 7 check bits and a spare bit. The ECC decoder sits outside the block. For every read it returns data that is already corrected, together with a two-bit status. A programmable interval separates successive locations, so the scrub traffic uses only a small share of memory bandwidth.

The sequencer treats each location as a short transaction:

- It reads the word.
- If the status is clean, it moves on to the next address.
- If the status shows a correctable error, it writes the corrected data back to the same address and then reads it again to verify it. The result of that second read decides whether the fault was transient (soft) or persistent (hard).
- If the status shows an uncorrectable error, it records that error and does not attempt a repair.

The block keeps one error record: a severity class and the address where that error occurred. The record keeps its contents until software clears it. A new error replaces the record only if it is more severe than the one already held. Requests go to the memory arbiter's scrub queue through a valid/ready handshake. Read responses come back later on a separate strobe.

Top module: `mem_scrub_seq`

## Requirements
- R1: After reset, `req_valid`, `busy` and `done` are 0, and the error record is empty (`err_type` = 0, `err_addr` = 0).
- R2: A `start` pulse while idle latches the first address, last address and interval, and clears `done`. A `start` pulse while `busy` is 1 has no effect on the sweep in progress.
- R3: After a start, and after each location finishes, the next location's read request rises exactly interval+1 cycles after the cycle in which the finishing response was accepted. `req_valid` never rises while the interval counter is non-zero.
- R4: A read status of clean (`resp_ecc` = 2'b00) completes the location with no write and no verify read. The address then advances by one word.
- R5: A read status of correctable (`resp_ecc` = 2'b01) causes a write to the same address, with `req_wdata` equal to the returned corrected `resp_data`. A verify read of that address follows.
- R6: Classification uses `err_type` codes 1 = soft, 2 = hard, 3 = uncorrectable:
  - a verify read that is clean gives soft;
  - a verify read that is correctable gives hard;
  - an uncorrectable status on any read (`resp_ecc[1]` = 1) gives uncorrectable;
  - an uncorrectable status on the first read skips the write and the verify read.
- R7: The record (`err_type`, `err_addr`) is replaced only by an error of strictly higher severity. Errors of equal or lower severity leave it unchanged.
- R8: An `err_clear` pulse returns `err_type` and `err_addr` to 0.
- R9: Once the location at the last address completes, `done` goes to 1, `busy` goes to 0, and no further request is issued until the next start. If the last address is below the first address, only the first address is scrubbed.
- R10: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_write`, `req_addr` and `req_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sweep (single-cycle pulse) |
| err_clear | input | 1 | Clear the error record (single-cycle pulse) |
| cfg_first | input | ADDR_W | First word address to scrub |
| cfg_last | input | ADDR_W | Last word address to scrub |
| cfg_interval | input | TMR_W | Idle cycles between locations |
| req_valid | output | 1 | Request to the scrub queue |
| req_ready | input | 1 | Scrub queue accepts the request |
| req_write | output | 1 | 1 = write of corrected data, 0 = read |
| req_addr | output | ADDR_W | Word address of the request |
| req_wdata | output | DATA_W | Corrected data for a write |
| resp_valid | input | 1 | Read response strobe |
| resp_ecc | input | 2 | 00 clean, 01 corrected, 1x uncorrectable |
| resp_data | input | DATA_W | Corrected read data |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished (held until the next start) |
| err_type | output | 2 | Held error class: 0 none, 1 soft, 2 hard, 3 uncorrectable |
| err_addr | output | ADDR_W | Address of the held error |

## Verification
Some properties are checked by assertions on every cycle:

- the request stays stable while it is stalled;
- a request never rises before the interval counter has reached zero;
- a clean or uncorrectable first read is never followed by a write;
- the severity in the record never decreases unless it is being cleared;
- nothing is requested once `done` is set.

Other behaviour can only be shown by the bench's scenarios, with a memory model that injects a fault class per address:

- that soft, hard and uncorrectable faults are classified correctly;
- that the repair write carries the corrected data;
- the number of reads and writes per sweep;
- that the held record ends up with the right address after mixed sequences of errors;
- the exact spacing set by the interval.

// File: rtl/scrub_pkg.sv
// Package: shared encodings for the scrub sequencer.
// Assumes: the external decoder reports status as 00 clean, 01 corrected,
// 1x uncorrectable.
package scrub_pkg;

    localparam logic [1:0] ECC_CLEAN = 2'b00;
    localparam logic [1:0] ECC_CORR  = 2'b01;

    typedef enum logic [1:0] {
        SEV_NONE   = 2'd0,
        SEV_SOFT   = 2'd1,
        SEV_HARD   = 2'd2,
        SEV_UNCORR = 2'd3
    } sev_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RD,
        ST_RD_WAIT,
        ST_WR,
        ST_VRD,
        ST_VRD_WAIT
    } scrub_st_e;

endpackage

// File: rtl/scrub_timer.sv
// Module: scrub_timer
// Paces the sweep. On arm it latches the interval and loads it into the
// counter. On load it reloads the latched interval. Otherwise it counts
// down to zero and then stays there.
// Assumes: arm and load are never both asserted in the same cycle.
module scrub_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             load,
    input  logic [TMR_W-1:0] period_in,
    output logic             zero
);
    logic [TMR_W-1:0] period_q;
    logic [TMR_W-1:0] cnt_q;

    // Latch the interval for the whole sweep.
    always_ff @(posedge clk) begin
        if (!rst_n)   period_q <= '0;
        else if (arm) period_q <= period_in;
    end

    // Count down from the loaded value and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (arm)           cnt_q <= period_in;
        else if (load)          cnt_q <= period_q;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/scrub_err_log.sv
// Module: scrub_err_log
// Holds one error record: a severity and an address. A new report replaces
// the record only when it is strictly more severe. A clear always wins.
// Assumes: log_en lasts a single cycle for each classified error.
module scrub_err_log #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              log_en,
    input  scrub_pkg::sev_e   log_sev,
    input  logic [ADDR_W-1:0] log_addr,
    output scrub_pkg::sev_e   sev_q,
    output logic [ADDR_W-1:0] addr_q
);
    import scrub_pkg::*;

    // Clear, or accept a strictly more severe report.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sev_q  <= SEV_NONE;
            addr_q <= '0;
        end else if (log_en && (log_sev > sev_q)) begin
            sev_q  <= log_sev;
            addr_q <= log_addr;
        end
    end

    // Severity only falls through a clear.
    a_r7_no_downgrade: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (sev_q >= $past(sev_q)));

    // An equal or lower report leaves the record untouched.
    a_r7_keep_on_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && log_en && (log_sev <= sev_q)) |=> ($stable(sev_q) && $stable(addr_q)));

endmodule

// File: rtl/scrub_ctrl.sv
// Module: scrub_ctrl
// Per-location sequencer. It waits for the timer, reads the word, and on a
// correctable status writes back the corrected data and reads it again to
// verify. It then classifies the error and advances or finishes.
// Assumes: exactly one response arrives for each accepted read. Writes get
// no response.
module scrub_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_first,
    input  logic [ADDR_W-1:0] cfg_last,
    input  logic              tmr_zero,
    output logic              tmr_arm,
    output logic              tmr_load,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              resp_valid,
    input  logic [1:0]        resp_ecc,
    input  logic [DATA_W-1:0] resp_data,
    output logic              log_en,
    output scrub_pkg::sev_e   log_sev,
    output logic              busy,
    output logic              done
);
    import scrub_pkg::*;

    scrub_st_e         st_q, st_d;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] last_q;
    logic [DATA_W-1:0] fix_q;
    logic              done_q;
    logic              loc_end;
    logic              at_last;

    assign at_last = (cur_q >= last_q);

    // Next state, timer control and error classification.
    always_comb begin
        st_d     = st_q;
        loc_end  = 1'b0;
        log_en   = 1'b0;
        log_sev  = SEV_NONE;
        tmr_arm  = 1'b0;
        tmr_load = 1'b0;
        unique case (st_q)
            ST_IDLE: if (start) begin
                st_d    = ST_WAIT;
                tmr_arm = 1'b1;
            end
            ST_WAIT: if (tmr_zero) st_d = ST_RD;
            ST_RD:   if (req_ready) st_d = ST_RD_WAIT;
            ST_RD_WAIT: if (resp_valid) begin
                if (resp_ecc == ECC_CLEAN) begin
                    loc_end = 1'b1;
                end else if (resp_ecc == ECC_CORR) begin
                    st_d = ST_WR;
                end else begin
                    log_en  = 1'b1;
                    log_sev = SEV_UNCORR;
                    loc_end = 1'b1;
                end
            end
            ST_WR:  if (req_ready) st_d = ST_VRD;
            ST_VRD: if (req_ready) st_d = ST_VRD_WAIT;
            ST_VRD_WAIT: if (resp_valid) begin
                log_en  = 1'b1;
                loc_end = 1'b1;
                if (resp_ecc == ECC_CLEAN)     log_sev = SEV_SOFT;
                else if (resp_ecc == ECC_CORR) log_sev = SEV_HARD;
                else                           log_sev = SEV_UNCORR;
            end
            default: st_d = ST_IDLE;
        endcase
        if (loc_end) begin
            if (at_last) begin
                st_d = ST_IDLE;
            end else begin
                st_d     = ST_WAIT;
                tmr_load = 1'b1;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Current and last address: latch on start, step one word after each location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            last_q <= '0;
        end else if (st_q == ST_IDLE && start) begin
            cur_q  <= cfg_first;
            last_q <= cfg_last;
        end else if (loc_end && !at_last) begin
            cur_q  <= cur_q + 1'b1;
        end
    end

    // Capture the corrected data for the repair write.
    always_ff @(posedge clk) begin
        if (!rst_n) fix_q <= '0;
        else if (st_q == ST_RD_WAIT && resp_valid) fix_q <= resp_data;
    end

    // Done flag: set at the end of the sweep, cleared by the next start.
    always_ff @(posedge clk) begin
        if (!rst_n)                           done_q <= 1'b0;
        else if (st_q == ST_IDLE && start)    done_q <= 1'b0;
        else if (loc_end && at_last)          done_q <= 1'b1;
    end

    // Request outputs.
    always_comb begin
        req_valid = (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_VRD);
        req_write = (st_q == ST_WR);
        req_addr  = cur_q;
        req_wdata = fix_q;
    end

    assign busy = (st_q != ST_IDLE);
    assign done = done_q;

    // A clean first read is never followed by a write.
    a_r4_clean_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RD_WAIT && resp_valid && resp_ecc == ECC_CLEAN) |=> !req_write);

    // An uncorrectable first read skips the repair write.
    a_r6_uncorr_skips_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RD_WAIT && resp_valid && resp_ecc[1]) |=> !req_write);

    // The repair write targets the address that was just read.
    a_r5_write_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RD_WAIT && resp_valid && resp_ecc == ECC_CORR) |=>
        (req_write && req_addr == $past(req_addr)));

endmodule

// File: rtl/mem_scrub_seq.sv
// Module: mem_scrub_seq (top)
// Memory scrub sequencer: sweeps a programmed word range at a programmed
// interval, repairs correctable errors by write-back plus verify read, and
// holds the most severe error seen.
// Assumes: the ECC decoder is external; resp_data is already corrected.
module mem_scrub_seq #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              err_clear,
    input  logic [ADDR_W-1:0] cfg_first,
    input  logic [ADDR_W-1:0] cfg_last,
    input  logic [TMR_W-1:0]  cfg_interval,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              resp_valid,
    input  logic [1:0]        resp_ecc,
    input  logic [DATA_W-1:0] resp_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_type,
    output logic [ADDR_W-1:0] err_addr
);
    import scrub_pkg::*;

    logic tmr_zero;
    logic tmr_arm;
    logic tmr_load;
    logic log_en;
    sev_e log_sev;
    sev_e sev_q;

    scrub_timer #(.TMR_W(TMR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (tmr_arm),
        .load      (tmr_load),
        .period_in (cfg_interval),
        .zero      (tmr_zero)
    );

    scrub_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_first  (cfg_first),
        .cfg_last   (cfg_last),
        .tmr_zero   (tmr_zero),
        .tmr_arm    (tmr_arm),
        .tmr_load   (tmr_load),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .resp_valid (resp_valid),
        .resp_ecc   (resp_ecc),
        .resp_data  (resp_data),
        .log_en     (log_en),
        .log_sev    (log_sev),
        .busy       (busy),
        .done       (done)
    );

    scrub_err_log #(.ADDR_W(ADDR_W)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (err_clear),
        .log_en   (log_en),
        .log_sev  (log_sev),
        .log_addr (req_addr),
        .sev_q    (sev_q),
        .addr_q   (err_addr)
    );

    assign err_type = sev_q;

    // A stalled request is held unchanged.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
        (req_valid && $stable(req_write) && $stable(req_addr) && $stable(req_wdata)));

    // A request only rises once the interval has run out.
    a_r3_paced: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> tmr_zero);

    // Nothing is requested after the sweep has finished.
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!req_valid && !busy));

endmodule

// File: tb/sim_mem_scrub_seq.sv
// Bench for mem_scrub_seq: a table of sweep scenarios with a per-address
// fault model, followed by directed tests for reset, clear, restart,
// ignored start and stalls.
module sim_mem_scrub_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int TW = 16;

    typedef struct packed {
        logic [3:0]  first;
        logic [3:0]  last;
        logic [7:0]  intv;
        logic [31:0] c1;      // first-read class, 2 bits per address
        logic [31:0] c2;      // class after a repair write
        logic        stall;
        logic [1:0]  exp_type;
        logic [3:0]  exp_addr;
        logic [7:0]  exp_rd;
        logic [7:0]  exp_wr;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{4'd2,  4'd5,  8'd5, 32'h0,        32'h0,        1'b0, 2'd0, 4'd0,  8'd4, 8'd0},
        '{4'd0,  4'd3,  8'd2, 32'h4,        32'h0,        1'b0, 2'd1, 4'd1,  8'd5, 8'd1},
        '{4'd4,  4'd7,  8'd0, 32'h400,      32'h400,      1'b0, 2'd2, 4'd5,  8'd5, 8'd1},
        '{4'd0,  4'd3,  8'd1, 32'h20,       32'h0,        1'b1, 2'd3, 4'd2,  8'd4, 8'd0},
        '{4'd0,  4'd3,  8'd1, 32'h11,       32'h10,       1'b0, 2'd2, 4'd2,  8'd6, 8'd2},
        '{4'd0,  4'd3,  8'd3, 32'h44,       32'h4,        1'b1, 2'd2, 4'd1,  8'd6, 8'd2},
        '{4'd8,  4'd11, 8'd1, 32'h120000,   32'h100000,   1'b0, 2'd3, 4'd8,  8'd5, 8'd1},
        '{4'd6,  4'd3,  8'd2, 32'h0,        32'h0,        1'b0, 2'd0, 4'd0,  8'd1, 8'd0},
        '{4'd12, 4'd12, 8'd0, 32'h1000000,  32'h2000000,  1'b0, 2'd3, 4'd12, 8'd2, 8'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          err_clear = 1'b0;
    logic [AW-1:0] cfg_first = '0;
    logic [AW-1:0] cfg_last = '0;
    logic [TW-1:0] cfg_interval = '0;
    logic          req_valid;
    logic          req_ready = 1'b1;
    logic          req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          resp_valid = 1'b0;
    logic [1:0]    resp_ecc = 2'b00;
    logic [DW-1:0] resp_data = '0;
    logic          busy;
    logic          done;
    logic [1:0]    err_type;
    logic [AW-1:0] err_addr;

    int n_tests = 0;
    int n_fail  = 0;

    // fault model state
    logic [31:0] c1_cur = '0;
    logic [31:0] c2_cur = '0;
    logic        stall_mode = 1'b0;
    logic        rdy_tog = 1'b0;
    logic        vflag [16];
    int          rd_n = 0;
    int          wr_n = 0;
    int          wd_bad = 0;
    int          pend = 0;
    logic [3:0]  pend_addr = '0;
    logic [1:0]  pend_cls = '0;
    logic        gap_on = 1'b0;
    int          gap_cnt = 0;
    int          gap = -1;
    logic [AW-1:0] last_rd_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_scrub_seq #(.ADDR_W(AW), .DATA_W(DW), .TMR_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .err_clear(err_clear),
        .cfg_first(cfg_first), .cfg_last(cfg_last), .cfg_interval(cfg_interval),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_ecc(resp_ecc), .resp_data(resp_data),
        .busy(busy), .done(done), .err_type(err_type), .err_addr(err_addr)
    );

    // Memory / ECC model, working on falling edges.
    always @(negedge clk) begin
        logic rdy;
        if (gap_on) begin
            if (req_valid) begin gap = gap_cnt; gap_on = 1'b0; end
            else gap_cnt++;
        end
        resp_valid = 1'b0;
        if (pend != 0) begin
            pend--;
            if (pend == 0) begin
                resp_valid = 1'b1;
                resp_ecc   = pend_cls;
                resp_data  = {16'hC0DE, 12'h0, pend_addr};
                gap_on = 1'b1;
                gap_cnt = 0;
            end
        end
        if (stall_mode) begin rdy_tog = ~rdy_tog; rdy = rdy_tog; end
        else rdy = 1'b1;
        req_ready = rdy;
        if (rst_n && req_valid && rdy) begin
            if (req_write) begin
                wr_n++;
                vflag[req_addr[3:0]] = 1'b1;
                if (req_wdata != {16'hC0DE, 12'h0, req_addr[3:0]}) wd_bad++;
            end else begin
                rd_n++;
                last_rd_addr = req_addr;
                pend_addr = req_addr[3:0];
                pend_cls  = vflag[req_addr[3:0]] ? c2_cur[2*req_addr[3:0] +: 2]
                                                 : c1_cur[2*req_addr[3:0] +: 2];
                vflag[req_addr[3:0]] = 1'b0;
                pend = 2;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk) err_clear = 1'b1;
        @(negedge clk) err_clear = 1'b0;
    endtask

    task automatic wait_done();
        int k;
        for (k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (done) break;
        end
        chk(done === 1'b1, "R9 sweep reaches done", int'(done), 1);
    endtask

    task automatic prep(input logic [31:0] c1, input logic [31:0] c2, input logic st);
        for (int i = 0; i < 16; i++) vflag[i] = 1'b0;
        c1_cur = c1; c2_cur = c2; stall_mode = st;
        rd_n = 0; wr_n = 0; wd_bad = 0; gap = -1;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) vflag[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_valid == 1'b0, "R1 req_valid after reset", int'(req_valid), 0);
        chk(done == 1'b0 && busy == 1'b0, "R1 done/busy after reset", int'({done, busy}), 0);
        chk(err_type == 2'd0 && err_addr == '0, "R1 record empty", int'(err_type), 0);

        // Scenario table: R2 R4 R5 R6 R7 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            prep(VEC[v].c1, VEC[v].c2, VEC[v].stall);
            cfg_first = AW'(VEC[v].first);
            cfg_last = AW'(VEC[v].last);
            cfg_interval = TW'(VEC[v].intv);
            pulse_clear();
            pulse_start();
            wait_done();
            @(negedge clk);
            chk(busy == 1'b0, "R9 busy low at end", int'(busy), 0);
            chk(rd_n == int'(VEC[v].exp_rd), "R4/R5/R6 read count", rd_n, int'(VEC[v].exp_rd));
            chk(wr_n == int'(VEC[v].exp_wr), "R5/R6 write count", wr_n, int'(VEC[v].exp_wr));
            chk(wd_bad == 0, "R5 write carries corrected data", wd_bad, 0);
            chk(err_type == VEC[v].exp_type, "R6/R7 error class", int'(err_type), int'(VEC[v].exp_type));
            chk(err_addr == AW'(VEC[v].exp_addr), "R7 error address", int'(err_addr), int'(VEC[v].exp_addr));
            if (v == 0) chk(gap == 6, "R3 interval spacing", gap, 6);
            if (v == 7) chk(last_rd_addr == 16'd6, "R9 last below first", int'(last_rd_addr), 6);
        end

        // R8: clear empties the record left by the last scenario
        pulse_clear();
        @(negedge clk);
        chk(err_type == 2'd0 && err_addr == '0, "R8 clear empties record", int'(err_type), 0);

        // R9: no request after done
        rd_n = 0;
        repeat (20) @(negedge clk);
        chk(rd_n == 0, "R9 quiet after done", rd_n, 0);

        // R3: zero interval spacing
        prep(32'h0, 32'h0, 1'b0);
        cfg_first = 16'd3; cfg_last = 16'd4; cfg_interval = '0;
        pulse_start();
        wait_done();
        chk(gap == 1, "R3 zero interval spacing", gap, 1);

        // R2: start while busy is ignored
        prep(32'h0, 32'h0, 1'b0);
        cfg_first = 16'd0; cfg_last = 16'd1; cfg_interval = 16'd3;
        pulse_start();
        cfg_first = 16'd9; cfg_last = 16'd9;
        pulse_start();
        wait_done();
        chk(rd_n == 2, "R2 start ignored while busy (reads)", rd_n, 2);
        chk(last_rd_addr == 16'd1, "R2 start ignored while busy (addr)", int'(last_rd_addr), 1);

        // R7: an equal-severity error does not overwrite the record
        prep(32'h44, 32'h44, 1'b0);
        cfg_first = 16'd0; cfg_last = 16'd3; cfg_interval = 16'd1;
        pulse_clear();
        pulse_start();
        wait_done();
        chk(err_type == 2'd2 && err_addr == 16'd1, "R7 equal severity keeps first", int'(err_addr), 1);

        // R1: reset in the middle of a sweep
        prep(32'h4, 32'h4, 1'b0);
        cfg_first = 16'd0; cfg_last = 16'd15; cfg_interval = 16'd2;
        pulse_start();
        repeat (15) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(req_valid == 1'b0 && busy == 1'b0, "R1 reset mid-sweep idle", int'(busy), 0);
        chk(err_type == 2'd0 && done == 1'b0, "R1 reset mid-sweep record", int'(err_type), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule